// File: doc/BRIEF.md
# Unsigned Word to Balanced Signed Digit Recoder

This block takes a wide unsigned integer, delivered as 39 words of 32 bits with word 0 least significant, and rewrites it as 96 signed digits of radix 2^13. Each digit lies in the balanced range −4096 to +4095, and the digits weighted by powers of 2^13 add back up to the input. A downstream multiplier can then form carry-free partial products on small signed coefficients.

No digit is compared with a threshold. The recoder first adds a fixed offset, which holds the value 4096 in every 13-bit field. It does this one 32-bit word per cycle, with a carry register between the words. Once the words are done, it cuts the offset sum into 13-bit fields and subtracts 4096 from each field. Because 39·32 = 96·13 = 1248, the fields tile the word vector exactly, and some fields straddle two adjacent words. For inputs below 2^1245 the sum never carries out of the top word, so a 97th digit would always be zero and is not produced.

A one-cycle start strobe loads the word vector. The result appears on a held digit vector together with a one-cycle done pulse.

Top module: `signed_digit_recoder`

## Requirements
- R1: With word k on `words_i[32k+31:32k]` and an input value below 2^1245, the sum over j of digit j · 2^(13j) equals the input value. Each digit is read as a 13-bit two's-complement number.
- R2: Digit j sits on `digits_o[13j+12:13j]` in 13-bit two's complement, and every digit lies in −4096..4095. An input of 4095 gives digit 0 = 4095 (0x0FFF). An input of 4096 gives digit 0 = −4096 (0x1000) and digit 1 = 1.
- R3: Digit j equals bits [13j+12:13j] of (input + B) minus 4096, taken modulo 2^13. B is the 1248-bit constant with bit i set exactly when i mod 13 = 12. An input of zero therefore gives all digits zero.
- R4: `done_o` is high for exactly one cycle. It rises on the 40th rising clock edge after the edge at which `start_i` is sampled high.
- R5: A start strobe sampled while a conversion is in progress is ignored. The running conversion keeps its timing and its result, and no extra done pulse follows.
- R6: A start strobe sampled in the last cycle before `done_o` rises begins a new conversion. The finishing conversion still delivers its own result, and the new result follows 40 edges later.
- R7: `digits_o` changes only on the edge that raises `done_o`. Changes on `words_i` without a start strobe do not affect it.
- R8: After a synchronous reset (`rst_n` low at a clock edge), `done_o` is 0 and `digits_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that loads `words_i` and begins a conversion |
| words_i | input | 1248 | Input value, 39 words of 32 bits, word 0 least significant |
| digits_o | output | 1248 | 96 signed 13-bit digits, digit 0 in the lowest bits |
| done_o | output | 1 | One-cycle pulse when `digits_o` takes a new result |

## Verification
Two functions can fall in the same cycle: delivering a finished result, and loading a new input vector into the same shift register that still holds that result. The bench provokes this by raising the next start strobe exactly in the cycle before the done pulse. It then requires the pulse to carry the first value's digits, and the following pulse to carry the second value's digits exactly 40 edges later. A strobe placed a few cycles into a conversion is checked the same way. That strobe must leave the result and the timing untouched and must add no second pulse.

// File: rtl/sdr_pkg.sv
// Package sdr_pkg
// Shared geometry defaults and the controller state type for the
// signed digit recoder. Assumes WORD_W*NUM_WORDS == DIGIT_W*NUM_DIGITS.
package sdr_pkg;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 39;
    localparam int DIGIT_W    = 13;
    localparam int NUM_DIGITS = 96;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BUSY   = 2'd1,
        ST_FINISH = 2'd2
    } sdr_state_t;
endpackage

// File: rtl/sdr_ctrl.sv
// Module sdr_ctrl
// Sequencer for one conversion. A start is accepted when the controller is
// idle or in the finishing cycle, and is ignored while busy. It steps the
// serial adder once per word and then raises a one-cycle capture and done.
// Assumes start_i is synchronous to clk.
module sdr_ctrl
    import sdr_pkg::*;
#(
    parameter int NUM_WORDS = sdr_pkg::NUM_WORDS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    output logic                         load_o,
    output logic                         step_o,
    output logic                         last_o,
    output logic [$clog2(NUM_WORDS)-1:0] idx_o,
    output logic                         capture_o,
    output logic                         done_o
);
    localparam int                 CNT_W = $clog2(NUM_WORDS);
    localparam logic [CNT_W-1:0]   LAST  = CNT_W'(NUM_WORDS - 1);

    sdr_state_t        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    // Decode the strobes that steer the datapath from the current state.
    always_comb begin
        load_o    = start_i && (state_q != ST_BUSY);
        step_o    = (state_q == ST_BUSY);
        last_o    = (cnt_q == LAST);
        capture_o = (state_q == ST_FINISH);
        idx_o     = cnt_q;
        done_o    = done_q;
    end

    // State, word counter and done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_BUSY;
                        cnt_q   <= '0;
                    end
                end
                ST_BUSY: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_FINISH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_FINISH: begin
                    done_q <= 1'b1;
                    if (start_i) begin
                        state_q <= ST_BUSY;
                        cnt_q   <= '0;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: done never lasts two cycles.
    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R5: a busy conversion advances by one word each cycle, whatever start does.
    assert_busy_ignores_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && cnt_q != LAST) |=>
            (state_q == ST_BUSY && cnt_q == $past(cnt_q) + 1'b1));

    // R6: a start in the finishing cycle restarts at word zero.
    assert_restart_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH && start_i) |=> (state_q == ST_BUSY && cnt_q == '0));
endmodule

// File: rtl/sdr_bias_adder.sv
// Module sdr_bias_adder
// Serial adder of the offset constant. The constant holds the value
// 2^(DIGIT_W-1) in every DIGIT_W-bit field. On load the input vector enters
// a shift register. Each step adds the lowest word, the matching offset word
// and the carry flip-flop, and shifts the sum in at the top. After NUM_WORDS
// steps the register holds input + offset. Assumes the input is small enough
// that the final word produces no carry.
module sdr_bias_adder #(
    parameter int WORD_W    = sdr_pkg::WORD_W,
    parameter int NUM_WORDS = sdr_pkg::NUM_WORDS,
    parameter int DIGIT_W   = sdr_pkg::DIGIT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic                          step_i,
    input  logic                          last_i,
    input  logic [$clog2(NUM_WORDS)-1:0]  idx_i,
    input  logic [WORD_W*NUM_WORDS-1:0]   words_i,
    output logic [WORD_W*NUM_WORDS-1:0]   value_o
);
    localparam int TOTAL = WORD_W * NUM_WORDS;

    // Offset word k: a bit is set where its absolute position is the top bit of a field.
    function automatic logic [WORD_W-1:0] offset_word(input int k);
        logic [WORD_W-1:0] w;
        w = '0;
        for (int b = 0; b < WORD_W; b++) begin
            w[b] = (((k * WORD_W + b) % DIGIT_W) == (DIGIT_W - 1));
        end
        return w;
    endfunction

    logic [WORD_W-1:0] offset_tbl [NUM_WORDS];

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_offset
        assign offset_tbl[k] = offset_word(k);
    end

    logic [TOTAL-1:0]  acc_q;
    logic              carry_q;
    logic [WORD_W:0]   sum;

    // One word of the offset addition, including the carry from the previous word.
    always_comb begin
        sum = {1'b0, acc_q[WORD_W-1:0]} + {1'b0, offset_tbl[idx_i]} + {{WORD_W{1'b0}}, carry_q};
    end

    // Load the input or rotate in one summed word per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else if (load_i) begin
            acc_q   <= words_i;
            carry_q <= 1'b0;
        end else if (step_i) begin
            acc_q   <= {sum[WORD_W-1:0], acc_q[TOTAL-1:WORD_W]};
            carry_q <= sum[WORD_W];
        end
    end

    assign value_o = acc_q;

    // R1: for legal inputs the offset sum fits in the word vector, so no 97th digit exists.
    assert_no_carry_out_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last_i) |-> !sum[WORD_W]);
endmodule

// File: rtl/sdr_field_slicer.sv
// Module sdr_field_slicer
// Cuts the offset sum into NUM_DIGITS consecutive DIGIT_W-bit fields, some
// of which straddle word boundaries, and recentres each field by
// subtracting 2^(DIGIT_W-1). The result is a two's-complement digit.
// Purely combinational.
module sdr_field_slicer #(
    parameter int DIGIT_W    = sdr_pkg::DIGIT_W,
    parameter int NUM_DIGITS = sdr_pkg::NUM_DIGITS
) (
    input  logic [DIGIT_W*NUM_DIGITS-1:0] value_i,
    output logic [DIGIT_W*NUM_DIGITS-1:0] digits_o
);
    localparam logic [DIGIT_W-1:0] HALF = DIGIT_W'(1) << (DIGIT_W - 1);

    for (genvar j = 0; j < NUM_DIGITS; j++) begin : g_digit
        // Recentre field j into the balanced signed range.
        assign digits_o[j*DIGIT_W +: DIGIT_W] = value_i[j*DIGIT_W +: DIGIT_W] - HALF;
    end
endmodule

// File: rtl/signed_digit_recoder.sv
// Module signed_digit_recoder
// Top of the recoder: controller, serial offset adder, field slicer and the
// held digit output register. Assumes the input value is below
// 2^(DIGIT_W*NUM_DIGITS-3), so the top digit would be zero and is dropped.
module signed_digit_recoder #(
    parameter int WORD_W     = sdr_pkg::WORD_W,
    parameter int NUM_WORDS  = sdr_pkg::NUM_WORDS,
    parameter int DIGIT_W    = sdr_pkg::DIGIT_W,
    parameter int NUM_DIGITS = sdr_pkg::NUM_DIGITS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [WORD_W*NUM_WORDS-1:0]   words_i,
    output logic [DIGIT_W*NUM_DIGITS-1:0] digits_o,
    output logic                          done_o
);
    localparam int TOTAL = WORD_W * NUM_WORDS;
    localparam int CNT_W = $clog2(NUM_WORDS);

    logic             load, step, last, capture;
    logic [CNT_W-1:0] idx;
    logic [TOTAL-1:0] biased;
    logic [TOTAL-1:0] sliced;
    logic [TOTAL-1:0] digits_q;

    sdr_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .load_o    (load),
        .step_o    (step),
        .last_o    (last),
        .idx_o     (idx),
        .capture_o (capture),
        .done_o    (done_o)
    );

    sdr_bias_adder #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (NUM_WORDS),
        .DIGIT_W   (DIGIT_W)
    ) u_adder (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .last_i  (last),
        .idx_i   (idx),
        .words_i (words_i),
        .value_o (biased)
    );

    sdr_field_slicer #(
        .DIGIT_W    (DIGIT_W),
        .NUM_DIGITS (NUM_DIGITS)
    ) u_slicer (
        .value_i  (biased),
        .digits_o (sliced)
    );

    // Hold the digits of the last finished conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digits_q <= '0;
        end else if (capture) begin
            digits_q <= sliced;
        end
    end

    assign digits_o = digits_q;

    // R7: the digit output only moves together with a done pulse.
    assert_digits_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(digits_o));
endmodule

// File: tb/test_signed_digit_recoder.sv
// Bench test_signed_digit_recoder
// Sweeps every single-bit input below the legal bound, plus edge patterns
// and random values. Expected digits are computed arithmetically, and the
// result is also checked by reconstructing the value from the digits.
module test_signed_digit_recoder;
    import sdr_pkg::*;

    localparam int TW      = WORD_W * NUM_WORDS;
    localparam int LEGAL_W = DIGIT_W * NUM_DIGITS - 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [TW-1:0] words_i = '0;
    logic [TW-1:0] digits_o;
    logic          done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    signed_digit_recoder i_signed_digit_recoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .words_i  (words_i),
        .digits_o (digits_o),
        .done_o   (done_o)
    );

    // Digits by the R3 rule: field of (a + B) minus 4096.
    function automatic logic [TW-1:0] exp_digits(input logic [TW-1:0] a);
        logic [TW-1:0] b;
        logic [TW-1:0] s;
        logic [TW-1:0] d;
        b = '0;
        for (int i = 0; i < TW; i++) b[i] = ((i % DIGIT_W) == DIGIT_W - 1);
        s = a + b;
        for (int j = 0; j < NUM_DIGITS; j++)
            d[j*DIGIT_W +: DIGIT_W] = s[j*DIGIT_W +: DIGIT_W] - 13'd4096;
        return d;
    endfunction

    // Weighted sum of signed digits (R1).
    function automatic logic [TW+11:0] rebuild(input logic [TW-1:0] d);
        logic signed [TW+11:0] acc;
        logic signed [TW+11:0] t;
        acc = '0;
        for (int j = 0; j < NUM_DIGITS; j++) begin
            t = $signed(d[j*DIGIT_W +: DIGIT_W]);
            acc = acc + (t <<< (DIGIT_W * j));
        end
        return acc;
    endfunction

    task automatic note(input bit ok, input string tag, input logic [TW+11:0] act,
                        input logic [TW+11:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Called at a negedge; returns one negedge later with start low.
    task automatic pulse_start(input logic [TW-1:0] a);
        words_i = a;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Counts negedges, starting from n0, until done is seen.
    task automatic wait_done(input int n0, output int n);
        n = n0;
        while (!done_o && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic convert(input logic [TW-1:0] a);
        int n;
        logic [TW-1:0] e;
        pulse_start(a);
        wait_done(1, n);
        note(n == 41, "R4 latency", TW'(n), TW'(41));
        e = exp_digits(a);
        note(digits_o == e, "R3 digits", {12'b0, digits_o}, {12'b0, e});
        note(rebuild(digits_o) == {12'b0, a}, "R1 rebuild", rebuild(digits_o), {12'b0, a});
        @(negedge clk);
        note(!done_o, "R4 pulse width", TW'(done_o), '0);
    endtask

    initial begin
        #(20 * 190000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [TW-1:0] legal_mask;
        logic [TW-1:0] va;
        logic [TW-1:0] vb;
        logic [TW-1:0] held;
        int n;
        legal_mask = (TW'(1) << LEGAL_W) - 1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state.
        note(!done_o, "R8 done after reset", TW'(done_o), '0);
        note(digits_o == '0, "R8 digits after reset", {12'b0, digits_o}, '0);

        // R3: zero gives all-zero digits.
        convert('0);
        note(digits_o == '0, "R3 zero input", {12'b0, digits_o}, '0);

        // R2: extreme digit values.
        convert(TW'(4095));
        note(digits_o[12:0] == 13'h0FFF, "R2 max digit", TW'(digits_o[12:0]), TW'(13'h0FFF));
        convert(TW'(4096));
        note(digits_o[12:0] == 13'h1000, "R2 min digit", TW'(digits_o[12:0]), TW'(13'h1000));
        note(digits_o[25:13] == 13'h0001, "R2 carry digit", TW'(digits_o[25:13]), TW'(1));

        // R1: largest legal value and alternating patterns.
        convert(legal_mask);
        convert({(TW/2){2'b10}} & legal_mask);
        convert({(TW/2){2'b01}} & legal_mask);

        // R1: every single-bit input in the legal range.
        for (int b = 0; b < LEGAL_W; b++) convert(TW'(1) << b);

        // R1: random values.
        for (int r = 0; r < 24; r++) begin
            for (int w = 0; w < NUM_WORDS; w++) va[w*WORD_W +: WORD_W] = $urandom;
            convert(va & legal_mask);
        end

        // R5: start strobe during a busy conversion is ignored.
        va = {(TW/4){4'h9}} & legal_mask;
        vb = {(TW/4){4'h6}} & legal_mask;
        pulse_start(va);
        repeat (3) @(negedge clk);
        pulse_start(vb);
        wait_done(5, n);
        note(n == 41, "R5 latency kept", TW'(n), TW'(41));
        note(digits_o == exp_digits(va), "R5 result kept", {12'b0, digits_o}, {12'b0, exp_digits(va)});
        wait_done(0, n);
        n = 0;
        repeat (50) begin
            @(negedge clk);
            if (done_o) n++;
        end
        note(n == 0, "R5 no extra done", TW'(n), '0);

        // R6: start in the finishing cycle overlaps with delivery.
        pulse_start(va);
        repeat (39) @(negedge clk);
        note(!done_o, "R6 done not early", TW'(done_o), '0);
        pulse_start(vb);
        note(done_o, "R6 first done", TW'(done_o), TW'(1));
        note(digits_o == exp_digits(va), "R6 first result", {12'b0, digits_o}, {12'b0, exp_digits(va)});
        @(negedge clk);
        wait_done(1, n);
        note(n == 40, "R6 second latency", TW'(n), TW'(40));
        note(digits_o == exp_digits(vb), "R6 second result", {12'b0, digits_o}, {12'b0, exp_digits(vb)});

        // R7: input changes without start leave the output alone.
        held = digits_o;
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            words_i = TW'(k) << (k * 100);
            @(negedge clk);
        end
        note(digits_o == held, "R7 digits held", {12'b0, digits_o}, {12'b0, held});
        note(!done_o, "R7 no done", TW'(done_o), '0);

        finish_run();
    end
endmodule